// File: doc/BRIEF.md
# Periodic Down-Count Tick Timer

This block is a periodic tick source for a processor subsystem. A 24-bit counter counts down toward zero. On the step after it reaches zero it reloads from a programmable reload register. Each time it steps from 1 to 0 it raises a sticky expiry flag and, if the interrupt enable is set, a one-cycle interrupt request. Software reaches three word registers through a plain register bus: a control/status word, the reload value and the live count.

A source-select bit sets the count rate. With the bit set, the counter steps on every core clock. With the bit clear, it steps once every eight core clocks. The slow rate comes from a clock-enable pulse made by a small prescaler, and that prescaler is cleared whenever the timer is off, so the phase of the first slow step is fixed. All registers reset to zero. After reset the timer is stopped and the slow rate is selected.

Top module: `sys_tick_timer`

## Requirements
- R1: After synchronous reset, every register reads 0 and `tick_irq` is low.
- R2: Word address 0 is the control/status word: bit 0 is run enable, bit 1 is interrupt enable, bit 2 is source select (1 = full rate) and bit 16 is the read-only expiry flag. Address 1 holds the reload value, of which only bits 23:0 are kept; the upper bits read 0. Address 2 reads the live count. Address 3 reads 0.
- R3: With run enable and source select both 1, the counter steps on every clock. A step from 0 loads the reload value and any other step decrements, so the period is reload+1 steps.
- R4: A step from 1 to 0 sets the expiry flag. If interrupt enable is 1, `tick_irq` is high for exactly the one cycle after that step.
- R5: With source select 0, the counter steps once every eight clocks. The first step comes on the eighth clock after run enable becomes set.
- R6: With interrupt enable 0, expiry still sets the flag but `tick_irq` stays low.
- R7: A read of the control/status word clears the expiry flag after that access. The read returns the flag value from before the clear.
- R8: Any write to address 2 forces the count to 0 and clears the expiry flag. The write takes priority over a step in the same cycle.
- R9: With reload 0, a counter at 0 stays at 0 and no expiry or interrupt occurs.
- R10: With run enable 0, the count holds its value.
- R11: Reload 0xFFFFFF is accepted and loaded in full, and the counter then decrements from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_rd | input | 1 | Read strobe; only the read side effect depends on it |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_irq | output | 1 | One-cycle interrupt request on expiry |

## Verification
A wrong count or prescaler phase shows up at the current-value address on the very next clock, because the bench keeps that address selected and compares it against a behavioural model every cycle. A bad flag or interrupt gate shows up in the control word or on `tick_irq` in the cycle after the 1-to-0 step. Errors in rate selection or reload handling show up within one period, which is at most eight clocks per step in the scenarios used.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int CNT_W    = 24;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int DIV_LOG2 = 3;

    // control/status field positions
    localparam int BIT_RUN  = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_FLAG = 16;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_LOAD = 2'd1,
        REG_VAL  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic src_full;
        logic irq_en;
        logic run;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c, input logic flag);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_RUN]  = c.run;
        w[BIT_IE]   = c.irq_en;
        w[BIT_SRC]  = c.src_full;
        w[BIT_FLAG] = flag;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run      = w[BIT_RUN];
        c.irq_en   = w[BIT_IE];
        c.src_full = w[BIT_SRC];
        return c;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PW = tick_pkg::DIV_LOG2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic pulse
);
    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run) phase_q <= '0;
        else             phase_q <= phase_q + 1'b1;
    end

    assign pulse = run && (phase_q == {PW{1'b1}});

    AST_PULSE_GAP: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse); // R5

    AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(run)); // R5
endmodule

// File: rtl/tick_counter_core.sv
module tick_counter_core #(
    parameter int CW = tick_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          irq_en,
    input  logic          cur_wr,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] cur,
    output logic          expire,
    output logic          irq
);
    logic [CW-1:0] cur_q;
    logic          irq_q;
    logic          at_zero;
    logic          at_one;

    assign at_zero = (cur_q == '0);
    assign at_one  = (cur_q == CW'(1));
    assign expire  = step && at_one && !cur_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= expire && irq_en;
            if (cur_wr)        cur_q <= '0;
            else if (step) begin
                if (at_zero)   cur_q <= reload;
                else           cur_q <= cur_q - CW'(1);
            end
        end
    end

    assign cur = cur_q;
    assign irq = irq_q;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R4

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(irq_en)); // R6

    AST_ZERO_RELOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reload) == '0 && $past(cur_q) == '0) |-> cur_q == '0); // R9

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(step) && !$past(cur_wr)) |-> $stable(cur_q)); // R10
endmodule

// File: rtl/tick_regfile.sv
module tick_regfile
    import tick_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CW-1:0]     cur,
    input  logic              expire,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl,
    output logic [CW-1:0]     reload,
    output logic              cur_wr
);
    localparam int PAD = DATA_W - CW;

    ctrl_t         ctrl_q;
    logic [CW-1:0] reload_q;
    logic          flag_q;
    reg_sel_e      sel;
    logic          ctrl_rd;

    assign sel     = reg_sel_e'(bus_addr);
    assign cur_wr  = bus_wr && (sel == REG_VAL);
    assign ctrl_rd = bus_rd && (sel == REG_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (bus_wr && sel == REG_CTRL) ctrl_q   <= unpack_ctrl(bus_wdata);
            if (bus_wr && sel == REG_LOAD) reload_q <= bus_wdata[CW-1:0];
            if (expire)                    flag_q   <= 1'b1;
            else if (cur_wr || ctrl_rd)    flag_q   <= 1'b0;
        end
    end

    always_comb begin
        case (sel)
            REG_CTRL: bus_rdata = pack_ctrl(ctrl_q, flag_q);
            REG_LOAD: bus_rdata = {{PAD{1'b0}}, reload_q};
            REG_VAL:  bus_rdata = {{PAD{1'b0}}, cur};
            default:  bus_rdata = '0;
        endcase
    end

    assign ctrl   = ctrl_q;
    assign reload = reload_q;

    AST_FLAG_ON_EXPIRE: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q); // R4

    AST_FLAG_CLEAR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cur_wr && !expire) |=> !flag_q); // R8

    AST_FLAG_CLEAR_READ: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd && !expire) |=> !flag_q); // R7
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
    import tick_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = DIV_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_irq
);
    ctrl_t         ctrl;
    logic [CW-1:0] reload;
    logic [CW-1:0] cur;
    logic          cur_wr;
    logic          expire;
    logic          slow_pulse;
    logic          step;

    generate
        if (PW == 0) begin : g_nodiv
            assign slow_pulse = ctrl.run;
        end else begin : g_div
            tick_prescaler #(.PW(PW)) u_psc (
                .clk  (clk),
                .rst  (rst),
                .run  (ctrl.run),
                .pulse(slow_pulse)
            );
        end
    endgenerate

    assign step = ctrl.run && (ctrl.src_full || slow_pulse);

    tick_regfile #(.CW(CW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .cur      (cur),
        .expire   (expire),
        .bus_rdata(bus_rdata),
        .ctrl     (ctrl),
        .reload   (reload),
        .cur_wr   (cur_wr)
    );

    tick_counter_core #(.CW(CW)) u_core (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .irq_en(ctrl.irq_en),
        .cur_wr(cur_wr),
        .reload(reload),
        .cur   (cur),
        .expire(expire),
        .irq   (tick_irq)
    );

    AST_STEP_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        step |-> ctrl.run); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !tick_irq); // R1
endmodule

// File: tb/sim_sys_tick_timer.sv
module sim_sys_tick_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_irq;

    int errors = 0;
    int checks = 0;
    int irq_seen = 0;
    bit chk_on = 0;
    string phase = "R1";

    // behavioural reference state
    int unsigned m_cur = 0, m_rld = 0, m_psc = 0;
    bit m_en = 0, m_ie = 0, m_src = 0, m_flag = 0, m_irq = 0;

    always #5 clk = ~clk;

    sys_tick_timer u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tick_irq(tick_irq)
    );

    function automatic int unsigned model_read(input logic [1:0] a);
        case (a)
            2'd0: return (int'(m_flag) << 16) | (int'(m_src) << 2) | (int'(m_ie) << 1) | int'(m_en);
            2'd1: return m_rld;
            2'd2: return m_cur;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit tick, cw, ev;
        if (rst) begin
            m_cur = 0; m_rld = 0; m_psc = 0; m_en = 0; m_ie = 0; m_src = 0;
            m_flag = 0; m_irq = 0;
        end else begin
            tick = m_en && (m_src || m_psc == 7);
            m_psc = m_en ? (m_psc + 1) % 8 : 0;
            cw = bus_wr && bus_addr == 2'd2;
            ev = 0;
            if (tick && !cw) begin
                if (m_cur == 0) m_cur = m_rld;
                else begin
                    if (m_cur == 1) ev = 1;
                    m_cur = m_cur - 1;
                end
            end
            m_irq = ev && m_ie;
            if (cw) begin m_cur = 0; m_flag = 0; end
            else if (bus_rd && bus_addr == 2'd0) m_flag = 0;
            if (ev) m_flag = 1;
            if (bus_wr && bus_addr == 2'd0) begin
                m_en = bus_wdata[0]; m_ie = bus_wdata[1]; m_src = bus_wdata[2];
            end
            if (bus_wr && bus_addr == 2'd1) m_rld = bus_wdata & 32'h00FF_FFFF;
        end
    end

    task automatic check(input string req, input string what, input int unsigned act, input int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            if (tick_irq) irq_seen++;
            check((phase == "R1") ? "R4" : phase, "irq", int'(tick_irq), int'(m_irq));
            check(phase, "rdata", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk); #1;
            bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd2;
        end
    endtask

    task automatic rd_check(input logic [1:0] a, input int unsigned exp, input string req);
        @(negedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
        #1 check(req, "register read", bus_rdata, exp);
    endtask

    task automatic finish_sim();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(10 * 100000);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        chk_on = 1;
        // R1 reset values
        rd_check(2'd0, 0, "R1");
        rd_check(2'd1, 0, "R1");
        rd_check(2'd2, 0, "R1");
        check("R1", "irq after reset", int'(tick_irq), 0);
        // R2 map and reload width
        phase = "R2";
        wr(2'd1, 32'hFF12_3456);
        rd_check(2'd1, 32'h0012_3456, "R2");
        rd_check(2'd3, 0, "R2");
        // R3 full rate, R8 write clears count
        phase = "R3";
        wr(2'd1, 5);
        wr(2'd0, 32'h7);
        wr(2'd2, 0);
        rd_check(2'd2, 0, "R8");
        rd_check(2'd2, 5, "R3");
        rd_check(2'd2, 4, "R3");
        // R4 interrupt count over a known window
        phase = "R4";
        wr(2'd2, 0);
        irq_seen = 0;
        idle(60);
        check("R4", "irq pulses in 59 steps of period 6", irq_seen, 9);
        // R5 divide-by-eight, first step on eighth enabled clock
        phase = "R5";
        wr(2'd0, 0);
        wr(2'd1, 2);
        wr(2'd2, 0);
        wr(2'd0, 32'h3);
        idle(7);
        rd_check(2'd2, 0, "R5");
        rd_check(2'd2, 2, "R5");
        idle(100);
        // R6 flag without interrupt, R7 read clears flag
        phase = "R6";
        wr(2'd0, 32'h5);
        wr(2'd1, 100);
        wr(2'd2, 0);
        irq_seen = 0;
        idle(120);
        check("R6", "irq with interrupt disabled", irq_seen, 0);
        phase = "R7";
        rd_check(2'd0, 32'h0001_0005, "R7");
        rd_check(2'd0, 32'h0000_0005, "R7");
        idle(120);
        phase = "R8";
        wr(2'd2, 0);
        rd_check(2'd0, 32'h0000_0005, "R8");
        // R9 zero reload
        phase = "R9";
        wr(2'd1, 0);
        wr(2'd2, 0);
        wr(2'd0, 32'h7);
        irq_seen = 0;
        idle(50);
        check("R9", "irq with zero reload", irq_seen, 0);
        rd_check(2'd2, 0, "R9");
        rd_check(2'd0, 32'h7, "R9");
        // R10 disabled holds count
        phase = "R10";
        wr(2'd1, 9);
        wr(2'd0, 32'h6);
        idle(20);
        rd_check(2'd2, 9, "R10");
        // R11 maximum reload
        phase = "R11";
        wr(2'd1, 32'h00FF_FFFF);
        wr(2'd0, 32'h5);
        wr(2'd2, 0);
        idle(1);
        rd_check(2'd2, 32'h00FF_FFFF, "R11");
        rd_check(2'd2, 32'h00FF_FFFE, "R11");
        idle(10);
        finish_sim();
    end
endmodule